// File: doc/BRIEF.md
# Copy-back line replacement controller

This block manages one block of a write-back data cache together with the small store buffer in front of it. It keeps the block's address tag and three status flags: valid, shared and modify. Core requests arrive on a valid/ready stream. Every store, hit or miss, is queued in the buffer. The buffer drains through a valid/ready stream towards the cache array and the memory side whenever the array accepts a beat. A store hit that is not write-through marks the block modified when it is accepted.

A load that misses the block starts a reallocation. The controller first waits until the store buffer is empty, because queued data cannot follow the block once it is assigned to a new address. It then raises a copy-back request, but only if the victim is valid and modified. After that it raises a reload request. When the reload completes, it rewrites the tag and status. Copy-back and reload are level request / single-cycle done handshakes with the surrounding engines.

Back-pressure rules: a core request is taken on a cycle where `req_valid` and `req_ready` are both high. The requester holds its fields stable until then. A drain beat leaves on a cycle where `drn_valid` and `drn_ready` are both high. `drn_valid` stays asserted and its fields stay stable until that happens.

Top module: `cb_line_ctrl`

## Requirements
- R1: While reset is held and on release, `req_ready` is high, `drn_valid`, `cb_req` and `rl_req` are low, and valid, shared, modify and tag all read zero.
- R2: Each accepted store appears on the drain stream exactly once, in acceptance order, with its tag and data. `drn_cache` is 1 when the store hit the block at acceptance. `drn_mem` is 1 when it missed or was write-through. A beat is removed only on a cycle with `drn_ready` high.
- R3: Outside a reallocation, `req_ready` is high exactly when the store buffer holds fewer than `WB_DEPTH` entries, so the buffer never overflows.
- R4: An accepted store with `req_wt`=0 whose tag matches a valid block sets the modify flag from the next cycle.
- R5: An accepted write-through store hit (`req_wt`=1) leaves the modify flag unchanged.
- R6: After a load miss is accepted, neither `cb_req` nor `rl_req` rises until the store buffer is empty.
- R7: A reallocation raises `cb_req`, with `cb_addr` equal to the victim tag, exactly when the victim was valid and modified. In that case `rl_req` waits for `cb_done`. A clean or invalid victim goes straight to reload.
- R8: `rl_addr` carries the missing tag. On the cycle after `rl_done`, the status is written: tag is set to the new tag, valid to 1, modify to 0, and shared to `rl_shared` as sampled with `rl_done`. It is visible when `req_ready` returns.
- R9: `req_ready` is low from the cycle after a load miss is accepted until one cycle after the status update.
- R10: An accepted load that hits, or a store that misses, changes neither the tag nor the status flags and starts no reallocation.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Store is write-through |
| req_tag | input | TAG_W | Request address tag |
| req_data | input | DATA_W | Store data |
| drn_valid | output | 1 | Buffered store available |
| drn_ready | input | 1 | Array/memory side takes the beat |
| drn_tag | output | TAG_W | Tag of the drained store |
| drn_data | output | DATA_W | Data of the drained store |
| drn_cache | output | 1 | Beat writes the cache array |
| drn_mem | output | 1 | Beat goes to memory |
| cb_req | output | 1 | Copy-back of the victim requested |
| cb_addr | output | TAG_W | Victim tag |
| cb_done | input | 1 | Copy-back finished (one cycle) |
| rl_req | output | 1 | Reload requested |
| rl_addr | output | TAG_W | Tag being reloaded |
| rl_done | input | 1 | Reload finished (one cycle) |
| rl_shared | input | 1 | Reloaded block is shared |
| stat_valid | output | 1 | Block valid flag |
| stat_shared | output | 1 | Block shared flag |
| stat_modify | output | 1 | Block modify flag |
| stat_tag | output | TAG_W | Block tag |

## Verification
The bench first runs a directed sequence:
- a miss on an invalid block,
- a write-through hit,
- a plain store hit,
- a store miss,
- a load hit,
- a load miss against the now-dirty block.

These separate the clean-victim and dirty-victim paths and the flag effect of each store kind. Random traffic follows over four tags, with random drain back-pressure and random copy-back and reload latencies. This traffic fills the buffer to test the stall rule (R3). It also lets misses arrive with a non-empty buffer, which separates a correct drain-before-copy-back order from one that starts the copy-back early.

// File: rtl/cb_line_pkg.sv
package cb_line_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DRAIN    = 3'd1,
    ST_COPYBACK = 3'd2,
    ST_RELOAD   = 3'd3,
    ST_UPDATE   = 3'd4
  } cbl_state_e;
endpackage

// File: rtl/cbl_wbuf.sv
module cbl_wbuf #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cbl_status.sv
module cbl_status #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_mod,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             load_shared,
  output logic             v,
  output logic             s,
  output logic             m,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v   <= 1'b0;
      s   <= 1'b0;
      m   <= 1'b0;
      tag <= '0;
    end else if (load) begin
      v   <= 1'b1;
      s   <= load_shared;
      m   <= 1'b0;
      tag <= load_tag;
    end else if (set_mod) begin
      m   <= 1'b1;
    end
  end
endmodule

// File: rtl/cbl_fsm.sv
module cbl_fsm
  import cb_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       miss_go,
  input  logic       wb_empty,
  input  logic       victim_dirty,
  input  logic       cb_done,
  input  logic       rl_done,
  output cbl_state_e state,
  output logic       cb_req,
  output logic       rl_req,
  output logic       load_stat
);
  cbl_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (miss_go)  nxt = ST_DRAIN;
      ST_DRAIN:    if (wb_empty) nxt = victim_dirty ? ST_COPYBACK : ST_RELOAD;
      ST_COPYBACK: if (cb_done)  nxt = ST_RELOAD;
      ST_RELOAD:   if (rl_done)  nxt = ST_UPDATE;
      ST_UPDATE:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign cb_req    = (state == ST_COPYBACK);
  assign rl_req    = (state == ST_RELOAD);
  assign load_stat = (state == ST_UPDATE);
endmodule

// File: rtl/cb_line_ctrl.sv
module cb_line_ctrl
  import cb_line_pkg::*;
#(
  parameter int TAG_W    = 20,
  parameter int DATA_W   = 32,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic              req_wt,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_data,
  output logic              drn_valid,
  input  logic              drn_ready,
  output logic [TAG_W-1:0]  drn_tag,
  output logic [DATA_W-1:0] drn_data,
  output logic              drn_cache,
  output logic              drn_mem,
  output logic              cb_req,
  output logic [TAG_W-1:0]  cb_addr,
  input  logic              cb_done,
  output logic              rl_req,
  output logic [TAG_W-1:0]  rl_addr,
  input  logic              rl_done,
  input  logic              rl_shared,
  output logic              stat_valid,
  output logic              stat_shared,
  output logic              stat_modify,
  output logic [TAG_W-1:0]  stat_tag
);
  localparam int ENT_W = TAG_W + DATA_W + 2;

  cbl_state_e       state;
  logic             hit, accept, miss_go, set_mod, load_stat;
  logic             wb_empty, wb_full, wb_push, wb_pop;
  logic [ENT_W-1:0] wb_in, wb_head;
  logic [TAG_W-1:0] pend_tag;
  logic             shared_q;

  assign hit       = stat_valid && (req_tag == stat_tag);
  assign req_ready = (state == ST_IDLE) && !wb_full;
  assign accept    = req_valid && req_ready;
  assign wb_push   = accept && req_store;
  assign set_mod   = wb_push && hit && !req_wt;
  assign miss_go   = accept && !req_store && !hit;
  assign wb_in     = {req_tag, req_data, hit, (!hit || req_wt)};
  assign wb_pop    = drn_valid && drn_ready;

  assign drn_valid = !wb_empty;
  assign {drn_tag, drn_data, drn_cache, drn_mem} = wb_head;

  cbl_wbuf #(.W(ENT_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .push(wb_push), .push_data(wb_in),
    .pop(wb_pop), .head(wb_head), .empty(wb_empty), .full(wb_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_tag <= '0;
      shared_q <= 1'b0;
    end else begin
      if (miss_go)          pend_tag <= req_tag;
      if (rl_req && rl_done) shared_q <= rl_shared;
    end
  end

  cbl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .miss_go(miss_go), .wb_empty(wb_empty),
    .victim_dirty(stat_valid && stat_modify), .cb_done(cb_done),
    .rl_done(rl_done), .state(state), .cb_req(cb_req), .rl_req(rl_req),
    .load_stat(load_stat)
  );

  cbl_status #(.TAG_W(TAG_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_mod(set_mod), .load(load_stat),
    .load_tag(pend_tag), .load_shared(shared_q), .v(stat_valid),
    .s(stat_shared), .m(stat_modify), .tag(stat_tag)
  );

  assign cb_addr = stat_tag;
  assign rl_addr = pend_tag;
endmodule

// File: rtl/cb_line_ctrl_chk.sv
module cb_line_ctrl_chk #(
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_store,
  input logic             req_wt,
  input logic [TAG_W-1:0] req_tag,
  input logic             drn_valid,
  input logic             cb_req,
  input logic             rl_req,
  input logic             rl_done,
  input logic             stat_valid,
  input logic             stat_modify,
  input logic [TAG_W-1:0] stat_tag
);
  logic st_hit;
  assign st_hit = req_valid && req_ready && req_store && stat_valid && (req_tag == stat_tag);

  p_mod_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !req_wt) |=> stat_modify);

  p_wt_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && req_wt && !stat_modify) |=> !stat_modify);

  p_drain_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_req || rl_req) |-> !drn_valid);

  p_dirty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cb_req) |-> (stat_valid && stat_modify));

  p_clean_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rl_req) && !$past(cb_req)) |-> !(stat_valid && stat_modify));

  p_fill_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_req && rl_done) |=> ##1 (stat_valid && !stat_modify));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_req || rl_req) |-> !req_ready);
endmodule

bind cb_line_ctrl cb_line_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_store(req_store), .req_wt(req_wt), .req_tag(req_tag),
  .drn_valid(drn_valid), .cb_req(cb_req), .rl_req(rl_req), .rl_done(rl_done),
  .stat_valid(stat_valid), .stat_modify(stat_modify), .stat_tag(stat_tag)
);

// File: tb/cb_line_ctrl_bench.sv
module cb_line_ctrl_bench;
  localparam int TAG_W = 20, DATA_W = 32, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_wt = 0, drn_ready = 0;
  logic cb_done = 0, rl_done = 0, rl_shared = 0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic req_ready, drn_valid, drn_cache, drn_mem, cb_req, rl_req;
  logic stat_valid, stat_shared, stat_modify;
  logic [TAG_W-1:0] drn_tag, cb_addr, rl_addr, stat_tag;
  logic [DATA_W-1:0] drn_data;

  always #2 clk = ~clk;

  cb_line_ctrl #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WB_DEPTH(DEPTH)) u_cb_line_ctrl (.*);

  typedef struct { logic [TAG_W-1:0] tag; logic [DATA_W-1:0] data; bit c; bit mm; } ent_t;
  ent_t q[$];
  int n_run = 0, n_fail = 0;

  bit m_v = 0, m_s = 0, m_m = 0;
  logic [TAG_W-1:0] m_tag = '0, victim = '0, new_tag = '0;
  bit pend = 0, exp_cb = 0, cb_given = 0, rl_given = 0, sh_given = 0, have = 0;

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit exp_ready();
    return !pend && (q.size() < DEPTH);
  endfunction

  // directed script: {store, wt, tag}
  function automatic logic [21:0] script(int i);
    case (i)
      0: return {1'b0, 1'b0, 20'd5};  // load miss, invalid victim
      1: return {1'b1, 1'b1, 20'd5};  // write-through hit (R5)
      2: return {1'b1, 1'b0, 20'd5};  // plain hit (R4)
      3: return {1'b1, 1'b0, 20'd9};  // store miss (R10)
      4: return {1'b0, 1'b0, 20'd5};  // load hit (R10)
      default: return {1'b0, 1'b0, 20'd6}; // load miss, dirty victim (R7)
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int sidx;
    void'($urandom(32'd4242));
    sidx = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready && !drn_valid && !cb_req && !rl_req, "R1 ctrl", {req_ready, drn_valid, cb_req, rl_req}, 4'b1000);
    chk({stat_valid, stat_shared, stat_modify, stat_tag} == '0, "R1 status",
        {stat_valid, stat_shared, stat_modify, stat_tag}, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (pend && rl_given && req_ready) begin
        m_v = 1; m_m = 0; m_s = sh_given; m_tag = new_tag; pend = 0;
      end
      chk(req_ready == exp_ready(), pend ? "R9" : "R3", req_ready, exp_ready());
      chk(drn_valid == (q.size() > 0), "R2 valid", drn_valid, q.size() > 0);
      if (drn_valid && q.size() > 0)
        chk({drn_tag, drn_data, drn_cache, drn_mem} == {q[0].tag, q[0].data, q[0].c, q[0].mm},
            "R2 beat", {drn_tag, drn_data, drn_cache, drn_mem}, {q[0].tag, q[0].data, q[0].c, q[0].mm});
      if (!pend) begin
        chk(stat_modify == m_m, "R4", stat_modify, m_m);
        chk({stat_valid, stat_shared, stat_tag} == {m_v, m_s, m_tag}, "R8",
            {stat_valid, stat_shared, stat_tag}, {m_v, m_s, m_tag});
      end
      if (cb_req) begin
        chk(pend && exp_cb && q.size() == 0, "R7 cb", {pend, exp_cb, q.size() == 0}, 3'b111);
        chk(cb_addr == victim, "R7 addr", cb_addr, victim);
      end
      if (rl_req) begin
        chk(pend && q.size() == 0, "R6", {pend, q.size() == 0}, 2'b11);
        chk(!exp_cb || cb_given, "R7 order", cb_given, exp_cb);
        chk(rl_addr == new_tag, "R8 addr", rl_addr, new_tag);
      end
      if (!pend && (cb_req || rl_req)) chk(1'b0, "R10", {cb_req, rl_req}, 0);

      drn_ready = $urandom_range(0, 2) != 0;
      cb_done = cb_req && ($urandom_range(0, 2) == 0);
      if (cb_done) cb_given = 1;
      rl_done = rl_req && ($urandom_range(0, 2) == 0);
      rl_shared = $urandom_range(0, 1);
      if (rl_done) begin rl_given = 1; sh_given = rl_shared; end
      if (!have) begin
        if (sidx < 6) begin
          {req_store, req_wt, req_tag} = script(sidx);
          sidx++;
          have = 1;
        end else if ($urandom_range(0, 1) == 1) begin
          req_store = $urandom_range(0, 2) != 0;
          req_wt = $urandom_range(0, 3) == 0;
          req_tag = TAG_W'($urandom_range(0, 3));
          have = 1;
        end
        req_data = $urandom;
      end
      req_valid = have;
      #1;
      if (drn_valid && drn_ready && q.size() > 0) void'(q.pop_front());
      if (req_valid && req_ready) begin
        bit h;
        h = m_v && (req_tag == m_tag);
        if (req_store) begin
          q.push_back('{tag: req_tag, data: req_data, c: h, mm: (!h || req_wt)});
          if (h && !req_wt) m_m = 1;
        end else if (!h) begin
          pend = 1; exp_cb = m_v && m_m; victim = m_tag; new_tag = req_tag;
          cb_given = 0; rl_given = 0;
        end
        have = 0;
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule